// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

The block turns parallel left and right 20-bit samples into one serial data line, framed by a bit clock, a left/right phase clock and a frame clock. All logic runs on one system clock. A strobe `sys_en_i` marks the 256fs rate inside that clock. As master, the block divides the 256fs strobe down to a 64fs bit clock and drives all three framing clocks. As slave, it releases those pins and follows framing clocks supplied from outside, after resynchronizing them to the system clock.

Each channel occupies a 32-bit-clock slot and its word is left-justified in the slot. Two format pins choose the bit order, the word length and the bit-clock edge on which data changes. A polarity pin sets which level of the phase clock marks the left channel. Samples arrive with a valid strobe and are held. They are copied into the transmit path only at the start of a frame, so a word never mixes two samples. Power-down and calibration inputs force the data line low and release the clock pins.

Top module: `audio_ser_tx`

## Requirements
- R1: While `rst_ni` is low, `sdata_o`, `bclk_o`, `lrck_o`, `fsync_o` and `clk_oe_o` are all low. In master mode `clk_oe_o` rises within a few cycles after reset is released.
- R2: In master mode (`slave_i`=0), the bit clock has a period of 4 `sys_en_i` strobes and starts each period low. The phase clock changes only on a falling bit-clock edge and holds each level for 32 bit clocks. The frame clock is high for the first 16 bit clocks of every slot, which gives two frame-clock pulses per sample.
- R3: `fmt_sel_i`=2'b01 sends the 20 sample bits MSB first. Data changes on falling bit-clock edges, so the receiver samples on rising edges.
- R4: `fmt_sel_i`=2'b11 sends the upper 16 sample bits MSB first, with data changing on falling edges. Sample bits 3..0 are dropped.
- R5: `fmt_sel_i`=2'b10 sends the 20 bits MSB first, with data changing on rising bit-clock edges. The receiver samples on falling edges.
- R6: `fmt_sel_i`=2'b00 sends the 20 bits LSB first, with data changing on falling edges.
- R7: With `lr_pol_i`=1, a high phase clock marks the left slot. With `lr_pol_i`=0, a low phase clock marks it. The left slot comes first in each frame.
- R8: With `slave_i`=1, `clk_oe_o` is low and `bclk_o`, `lrck_o` and `fsync_o` are held low. Data is framed by `bclk_i`, `lrck_i` and `fsync_i`.
- R9: While `pwr_dn_i` or `cal_i` is high, `sdata_o` is low from the next cycle on, and `clk_oe_o` and the clock outputs are low.
- R10: A sample pair written with `sample_vld_i` is sent starting from the next frame, which begins at a left slot start with the frame clock high. A write made in the middle of a frame leaves that frame's words unchanged.
- R11: Slot bits after the last word bit are zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sys_en_i | input | 1 | 256fs rate strobe |
| slave_i | input | 1 | 1 = slave (clocks are inputs), 0 = master |
| fmt_sel_i | input | 2 | Word format select (see R3 to R6) |
| lr_pol_i | input | 1 | Phase-clock polarity for the left channel |
| pwr_dn_i | input | 1 | Power-down: data low, clock pins released |
| cal_i | input | 1 | Calibration cycle: data low, clock pins released |
| sample_l_i | input | 20 | Left sample |
| sample_r_i | input | 20 | Right sample |
| sample_vld_i | input | 1 | Writes both samples into the holding registers |
| bclk_i | input | 1 | External bit clock (slave) |
| lrck_i | input | 1 | External phase clock (slave) |
| fsync_i | input | 1 | External frame clock (slave) |
| bclk_o | output | 1 | Bit clock (master) |
| lrck_o | output | 1 | Phase clock (master) |
| fsync_o | output | 1 | Frame clock (master) |
| clk_oe_o | output | 1 | High while the three clock outputs are driven |
| sdata_o | output | 1 | Serial data |

## Verification
The assertions assume that the polarity pin does not change in the same cycle as a phase-clock edge they judge. They also assume that `sys_en_i` is the only thing that advances the master divider. The bench holds `lr_pol_i` steady during each captured frame and drives the external clocks in slave mode. It keeps at least six system clocks per half bit, well above the synchronizer and edge-detect latency. In slave mode the bench changes the external phase clock only together with a falling bit-clock edge, and raises the frame clock at each slot start, as a well-behaved master would.

// File: rtl/audio_ser_pkg.sv
package audio_ser_pkg;
  localparam int unsigned SAMPLE_W = 20;
  localparam int unsigned SLOT_W   = 32;
  localparam int unsigned SHORT_W  = 16;

  // encoding is {mode_a, mode_b} as seen on fmt_sel_i
  typedef enum logic [1:0] {
    FMT_LSB20_FALL = 2'b00,
    FMT_MSB20_FALL = 2'b01,
    FMT_MSB20_RISE = 2'b10,
    FMT_MSB16_FALL = 2'b11
  } fmt_e;
endpackage

// File: rtl/asr_sync.sv
module asr_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  generate
    if (STAGES > 1) begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= '0;
        else         stg_q <= {stg_q[STAGES-2:0], d_i};
      end
    end else begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= '0;
        else         stg_q[0] <= d_i;
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/asr_clkgen.sv
module asr_clkgen #(
  parameter int unsigned SLOT_W   = 32,
  parameter int unsigned BCLK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic pol_i,
  output logic bclk_o,
  output logic lrck_o,
  output logic fsync_o
);
  localparam int unsigned DIV_W = $clog2(BCLK_DIV);
  localparam int unsigned CNT_W = $clog2(2 * SLOT_W * BCLK_DIV);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  // slot MSB flips with the low divider bits at zero: always on a bclk fall
  assign bclk_o  = cnt_q[DIV_W-1];
  assign lrck_o  = cnt_q[CNT_W-1] ^ pol_i;
  assign fsync_o = ~cnt_q[CNT_W-2];
endmodule

// File: rtl/asr_serializer.sv
module asr_serializer
  import audio_ser_pkg::*;
#(
  parameter int unsigned SAMPLE_W = audio_ser_pkg::SAMPLE_W,
  parameter int unsigned SLOT_W   = audio_ser_pkg::SLOT_W,
  parameter int unsigned SHORT_W  = audio_ser_pkg::SHORT_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bclk_i,
  input  logic                lrck_i,
  input  logic                fsync_i,
  input  fmt_e                fmt_i,
  input  logic                pol_i,
  input  logic                gate_i,
  input  logic [SAMPLE_W-1:0] hold_l_i,
  input  logic [SAMPLE_W-1:0] hold_r_i,
  output logic                sdata_o
);
  logic                bclk_q, lrck_seen_q, sdata_q;
  logic [SLOT_W-1:0]   sh_q, ld_word;
  logic [SAMPLE_W-1:0] cur_l_q, cur_r_q, sel_sample;
  logic                act_edge, slot_start, is_left, frame_start, nxt_bit;

  function automatic logic [SLOT_W-1:0] build_word(input logic [SAMPLE_W-1:0] s,
                                                   input fmt_e f);
    logic [SLOT_W-1:0] w;
    w = '0;
    for (int i = 0; i < SAMPLE_W; i++) begin
      if (f == FMT_LSB20_FALL)
        w[SLOT_W-1-i] = s[i];
      else if (f != FMT_MSB16_FALL || i < SHORT_W)
        w[SLOT_W-1-i] = s[SAMPLE_W-1-i];
    end
    return w;
  endfunction

  assign act_edge    = (fmt_i == FMT_MSB20_RISE) ? (bclk_i & ~bclk_q) : (~bclk_i & bclk_q);
  assign slot_start  = act_edge && (lrck_i != lrck_seen_q);
  assign is_left     = (lrck_i == pol_i);
  assign frame_start = slot_start && is_left && fsync_i;
  assign sel_sample  = !is_left ? cur_r_q : (frame_start ? hold_l_i : cur_l_q);
  assign ld_word     = build_word(sel_sample, fmt_i);
  assign nxt_bit     = slot_start ? ld_word[SLOT_W-1] : sh_q[SLOT_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q      <= 1'b0;
      lrck_seen_q <= 1'b0;
      sh_q        <= '0;
      cur_l_q     <= '0;
      cur_r_q     <= '0;
      sdata_q     <= 1'b0;
    end else begin
      bclk_q <= bclk_i;
      if (act_edge) begin
        lrck_seen_q <= lrck_i;
        sh_q        <= slot_start ? {ld_word[SLOT_W-2:0], 1'b0} : {sh_q[SLOT_W-2:0], 1'b0};
      end
      if (frame_start) begin
        cur_l_q <= hold_l_i;
        cur_r_q <= hold_r_i;
      end
      if (gate_i)        sdata_q <= 1'b0;
      else if (act_edge) sdata_q <= nxt_bit;
    end
  end

  assign sdata_o = sdata_q;
endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx
  import audio_ser_pkg::*;
#(
  parameter int unsigned SAMPLE_W    = audio_ser_pkg::SAMPLE_W,
  parameter int unsigned SLOT_W      = audio_ser_pkg::SLOT_W,
  parameter int unsigned SHORT_W     = audio_ser_pkg::SHORT_W,
  parameter int unsigned BCLK_DIV    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sys_en_i,
  input  logic                slave_i,
  input  logic [1:0]          fmt_sel_i,
  input  logic                lr_pol_i,
  input  logic                pwr_dn_i,
  input  logic                cal_i,
  input  logic [SAMPLE_W-1:0] sample_l_i,
  input  logic [SAMPLE_W-1:0] sample_r_i,
  input  logic                sample_vld_i,
  input  logic                bclk_i,
  input  logic                lrck_i,
  input  logic                fsync_i,
  output logic                bclk_o,
  output logic                lrck_o,
  output logic                fsync_o,
  output logic                clk_oe_o,
  output logic                sdata_o
);
  logic                gate, oe_q;
  logic                int_bclk, int_lrck, int_fsync;
  logic [2:0]          ext_s;
  logic                src_bclk, src_lrck, src_fsync;
  logic [SAMPLE_W-1:0] hold_l_q, hold_r_q;

  assign gate = pwr_dn_i | cal_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q     <= 1'b0;
      hold_l_q <= '0;
      hold_r_q <= '0;
    end else begin
      oe_q <= ~slave_i & ~gate;
      if (sample_vld_i) begin
        hold_l_q <= sample_l_i;
        hold_r_q <= sample_r_i;
      end
    end
  end

  asr_clkgen #(.SLOT_W(SLOT_W), .BCLK_DIV(BCLK_DIV)) u_clkgen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (sys_en_i),
    .pol_i   (lr_pol_i),
    .bclk_o  (int_bclk),
    .lrck_o  (int_lrck),
    .fsync_o (int_fsync)
  );

  asr_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({fsync_i, lrck_i, bclk_i}),
    .q_o    (ext_s)
  );

  assign src_bclk  = oe_q ? int_bclk  : ext_s[0];
  assign src_lrck  = oe_q ? int_lrck  : ext_s[1];
  assign src_fsync = oe_q ? int_fsync : ext_s[2];

  asr_serializer #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W), .SHORT_W(SHORT_W)) u_ser (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bclk_i   (src_bclk),
    .lrck_i   (src_lrck),
    .fsync_i  (src_fsync),
    .fmt_i    (fmt_e'(fmt_sel_i)),
    .pol_i    (lr_pol_i),
    .gate_i   (gate),
    .hold_l_i (hold_l_q),
    .hold_r_i (hold_r_q),
    .sdata_o  (sdata_o)
  );

  assign bclk_o   = oe_q & int_bclk;
  assign lrck_o   = oe_q & int_lrck;
  assign fsync_o  = oe_q & int_fsync;
  assign clk_oe_o = oe_q;
endmodule

// File: rtl/audio_ser_tx_chk.sv
module audio_ser_tx_chk #(
  parameter int unsigned SAMPLE_W = 20
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                sys_en_i,
  input logic                slave_i,
  input logic [1:0]          fmt_sel_i,
  input logic                lr_pol_i,
  input logic                pwr_dn_i,
  input logic                cal_i,
  input logic [SAMPLE_W-1:0] sample_l_i,
  input logic [SAMPLE_W-1:0] sample_r_i,
  input logic                sample_vld_i,
  input logic                bclk_i,
  input logic                lrck_i,
  input logic                fsync_i,
  input logic                bclk_o,
  input logic                lrck_o,
  input logic                fsync_o,
  input logic                clk_oe_o,
  input logic                sdata_o
);
  a_r9_gate_data_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_dn_i || cal_i) |=> !sdata_o);

  a_r9_gate_release_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_dn_i || cal_i) |=> !clk_oe_o);

  a_r8_slave_release_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slave_i |=> !clk_oe_o);

  a_r8_idle_pins_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_oe_o |-> (!bclk_o && !lrck_o && !fsync_o));

  a_r2_master_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!slave_i && !pwr_dn_i && !cal_i) |=> clk_oe_o);

  a_r2_bclk_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_oe_o && !sys_en_i) |=> (!clk_oe_o || $stable(bclk_o)));

  a_r2_lrck_on_bclk_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_oe_o && $past(clk_oe_o) && (lr_pol_i == $past(lr_pol_i)) && (lrck_o != $past(lrck_o)))
      |-> $fell(bclk_o));
endmodule

bind audio_ser_tx audio_ser_tx_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (.*);

// File: tb/audio_ser_tx_tb.sv
module audio_ser_tx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 6;
  localparam int EXT_FRAME  = 64 * 2 * HALF_BIT;
  localparam int NVEC       = 9;

  // {slave, fmt[1:0], pol, left[19:0], right[19:0]}
  localparam logic [43:0] VEC [NVEC] = '{
    {1'b0, 2'b01, 1'b1, 20'hA5C3F, 20'h1234B},
    {1'b0, 2'b11, 1'b1, 20'hFFFFF, 20'h8000F},
    {1'b0, 2'b10, 1'b1, 20'h6D2E1, 20'h9B17C},
    {1'b0, 2'b00, 1'b1, 20'h80001, 20'h00F0E},
    {1'b0, 2'b01, 1'b0, 20'h3C3C3, 20'hC3C3C},
    {1'b1, 2'b01, 1'b1, 20'h7E81A, 20'h2468B},
    {1'b1, 2'b00, 1'b0, 20'hF0001, 20'h0ACE5},
    {1'b1, 2'b10, 1'b1, 20'h55AAF, 20'hAA550},
    {1'b1, 2'b11, 1'b0, 20'h13579, 20'hFEDCB}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic sys_en = 1'b1, en_half = 1'b0;
  logic slave = 1'b0, pol = 1'b1, pwr_dn = 1'b0, cal = 1'b0, vld = 1'b0;
  logic [1:0]  fmt = 2'b01;
  logic [19:0] s_l = '0, s_r = '0;
  logic ext_bclk = 1'b0, ext_lrck = 1'b0, ext_fsync = 1'b0, ext_pol = 1'b1;
  logic bclk_o, lrck_o, fsync_o, clk_oe_o, sdata_o;
  int n_chk = 0, n_bad = 0;
  int cap_phase = 0, cap_idx = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_ser_tx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sys_en_i(sys_en), .slave_i(slave),
    .fmt_sel_i(fmt), .lr_pol_i(pol), .pwr_dn_i(pwr_dn), .cal_i(cal),
    .sample_l_i(s_l), .sample_r_i(s_r), .sample_vld_i(vld),
    .bclk_i(ext_bclk), .lrck_i(ext_lrck), .fsync_i(ext_fsync),
    .bclk_o(bclk_o), .lrck_o(lrck_o), .fsync_o(fsync_o),
    .clk_oe_o(clk_oe_o), .sdata_o(sdata_o)
  );

  initial forever begin
    @(negedge clk);
    sys_en = en_half ? ~sys_en : 1'b1;
  end

  // external master model: phase clock moves with the bit-clock fall
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph + 1) % EXT_FRAME;
      ext_bclk  = (ph % (2*HALF_BIT)) >= HALF_BIT;
      ext_lrck  = (ph / (2*HALF_BIT) < 32) ? ext_pol : ~ext_pol;
      ext_fsync = ((ph / (2*HALF_BIT)) % 32) < 16;
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    summary();
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic [19:0] s, input logic [1:0] f);
    logic [31:0] w;
    case (f)
      2'b11:   w = {s[19:4], 16'h0};
      2'b00: begin
        w = '0;
        for (int k = 0; k < 20; k++) w[31-k] = s[k];
      end
      default: w = {s, 12'h0};
    endcase
    return w;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic load(input logic [19:0] l, input logic [19:0] r);
    @(negedge clk); s_l = l; s_r = r; vld = 1'b1;
    @(negedge clk); vld = 1'b0;
  endtask

  // receiver: slot starts at the data-change edge where the phase clock shows a new level
  task automatic capture(output logic [31:0] wl, output logic [31:0] wr, output bit ok);
    logic rise_fmt, pb, pl, cb, cl, seen;
    int ch, guard;
    rise_fmt = (fmt == 2'b10);
    wl = '0; wr = '0; ok = 1'b0; cap_phase = 0; cap_idx = 0; ch = 0;
    tick(1);
    pb = slave ? ext_bclk : bclk_o;
    pl = slave ? ext_lrck : lrck_o;
    seen = pl;
    for (guard = 0; guard < 4 * EXT_FRAME; guard++) begin
      tick(1);
      cb = slave ? ext_bclk : bclk_o;
      cl = slave ? ext_lrck : lrck_o;
      if (rise_fmt ? (cb && !pb) : (!cb && pb)) begin
        if (cl != seen) begin
          ch = (cl == pol) ? 0 : 1;
          cap_idx = 0;
          if (cap_phase == 0 && ch == 0) cap_phase = 1;
          else if (cap_phase == 1 && ch == 1) cap_phase = 2;
          else if (cap_phase == 2 && ch == 0) begin ok = 1'b1; cap_phase = 3; break; end
        end else cap_idx++;
        seen = cl;
      end else if (rise_fmt ? (!cb && pb) : (cb && !pb)) begin
        if (cap_phase == 1 && cap_idx < 32) wl[31-cap_idx] = sdata_o;
        if (cap_phase == 2 && cap_idx < 32) wr[31-cap_idx] = sdata_o;
      end
      pb = cb; pl = cl;
    end
  endtask

  task automatic run_len(input logic which, output int len);
    logic p, c;
    len = 0;
    tick(1);
    p = which ? fsync_o : bclk_o;
    for (int g = 0; g < 2000; g++) begin
      tick(1);
      c = which ? fsync_o : bclk_o;
      if (c && !p) break;
      p = c;
    end
    for (int g = 0; g < 2000; g++) begin
      tick(1);
      c = which ? fsync_o : bclk_o;
      len++;
      if (c && !p && len > 1) break;
      p = c;
    end
  endtask

  initial begin
    logic [31:0] wl, wr;
    bit ok;
    int len;
    string tag;

    // R1: reset state
    tick(3);
    check("R1 reset outputs", {27'h0, sdata_o, bclk_o, lrck_o, fsync_o, clk_oe_o}, 32'h0);
    rst_n = 1'b1;
    tick(3);
    check("R1 master drives after reset", {31'h0, clk_oe_o}, 32'h1);

    // R2: master clock shape
    run_len(1'b0, len);
    check("R2 bclk period, strobe every cycle", len, 32'd4);
    run_len(1'b1, len);
    check("R2 frame clock period (2fs)", len, 32'd128);
    len = 0;
    for (int g = 0; g < 600 && !(lrck_o === 1'b1); g++) tick(1);
    for (int g = 0; g < 600 && lrck_o === 1'b1; g++) tick(1);
    for (int g = 0; g < 600 && lrck_o === 1'b0; g++) tick(1);
    for (int g = 0; g < 600 && lrck_o === 1'b1; g++) begin tick(1); len++; end
    check("R2 phase clock level length", len, 32'd128);
    len = 0;
    for (int g = 0; g < 600 && fsync_o === 1'b1; g++) tick(1);
    for (int g = 0; g < 600 && fsync_o === 1'b0; g++) tick(1);
    for (int g = 0; g < 600 && fsync_o === 1'b1; g++) begin tick(1); len++; end
    check("R2 frame clock high length", len, 32'd64);
    en_half = 1'b1;
    run_len(1'b0, len);
    check("R2 bclk period, strobe every other cycle", len, 32'd8);
    en_half = 1'b0;
    tick(4);

    // table of formats, polarities and clock modes
    for (int v = 0; v < NVEC; v++) begin
      slave = VEC[v][43]; fmt = VEC[v][42:41]; pol = VEC[v][40]; ext_pol = VEC[v][40];
      load(VEC[v][39:20], VEC[v][19:0]);
      capture(wl, wr, ok);
      capture(wl, wr, ok);
      case (fmt)
        2'b01:   tag = "R3 msb20 fall";
        2'b11:   tag = "R4/R11 msb16 fall";
        2'b10:   tag = "R5 msb20 rise";
        default: tag = "R6 lsb20 fall";
      endcase
      if (slave) tag = {tag, " R8 slave"};
      if (!pol)  tag = {tag, " R7 pol low"};
      check({tag, " capture"}, {31'h0, ok}, 32'h1);
      check({tag, " left R11"}, wl, exp_word(VEC[v][39:20], fmt));
      check({tag, " right R11"}, wr, exp_word(VEC[v][19:0], fmt));
      check({tag, " R8 pin drive"}, {31'h0, clk_oe_o}, {31'h0, ~slave});
    end

    // R10: a write in mid-frame waits for the next frame
    slave = 1'b0; fmt = 2'b01; pol = 1'b1; ext_pol = 1'b1;
    load(20'h12345, 20'h6789A);
    capture(wl, wr, ok);
    fork
      capture(wl, wr, ok);
      begin
        wait (cap_phase == 1 && cap_idx == 10);
        load(20'hFEDCB, 20'hA9876);
      end
    join
    check("R10 mid-frame write left unchanged", wl, exp_word(20'h12345, 2'b01));
    check("R10 mid-frame write right unchanged", wr, exp_word(20'h6789A, 2'b01));
    capture(wl, wr, ok);
    check("R10 next frame carries new left", wl, exp_word(20'hFEDCB, 2'b01));

    // R9: power-down and calibration force data low and release the pins
    load(20'hFFFFF, 20'hFFFFF);
    capture(wl, wr, ok);
    for (int m = 0; m < 2; m++) begin
      logic seen_hi;
      seen_hi = 1'b0;
      @(negedge clk);
      if (m == 0) pwr_dn = 1'b1; else cal = 1'b1;
      tick(1);
      for (int g = 0; g < 400; g++) begin
        tick(1);
        seen_hi |= sdata_o | clk_oe_o | bclk_o | lrck_o | fsync_o;
      end
      check(m == 0 ? "R9 power-down holds pins low" : "R9 calibration holds pins low",
            {31'h0, seen_hi}, 32'h0);
      @(negedge clk); pwr_dn = 1'b0; cal = 1'b0;
    end
    capture(wl, wr, ok);
    capture(wl, wr, ok);
    check("R9 data resumes after release", wl, exp_word(20'hFFFFF, 2'b01));

    summary();
  end
endmodule